// File: doc/BRIEF.md
# HDLC Receive FIFO with Host Register Window

This block sits between an HDLC receiver that has already removed flags, stuffing and CRC and a microcontroller that collects the frame data. The line side hands over one byte per cycle with a valid strobe and marks the last byte of each frame with an end strobe. The bytes go into a 32-byte store. The stream is cut into blocks whose size the host selects (4, 8, 16 or 32 bytes).

Each full block becomes a block-ready event. The end of a frame becomes a message-end event, and a count register gives the length of the last piece of the frame. Events are handed to the host one at a time. The host reads the data through a 32-address window whose internal pointer advances on every read, so a string-move burst works from any start address. The host then writes a release command, which frees the storage and allows the next event through. If a byte arrives while all 32 bytes are still held, the byte is dropped and an overflow status bit is set. The status register clears on read. A level interrupt output is driven by the unmasked status bits.

Top module: `hrf_rx_fifo_host`

## Requirements
- R1: A host read at any address 0x00 to 0x1F returns the stored byte at the internal read pointer in the same cycle, and the pointer moves to the next byte after each such read.
- R2: When B bytes of a frame have been stored without an end strobe, a block-ready event is raised as status bit 6. B is 4, 8, 16 or 32 for block-select values 0, 1, 2 and 3.
- R3: When the byte carrying the end strobe is stored, a message-end event is raised as status bit 7. A read at address 0x21 then returns the number of bytes in the frame's last block, from 1 to B. A frame that ends exactly on a block boundary raises only message-end, and the count equals B.
- R4: A byte that arrives while 32 unreleased bytes are held is discarded together with its end strobe, and status bit 5 (overflow) is set.
- R5: Only one event is presented at a time. The next event is presented only after the host writes 0x80 to address 0x22. A write of any other value there has no effect.
- R6: A release frees the presented event's bytes and places the read pointer on the first byte of the next event, however many bytes the host read.
- R7: A read at address 0x20 returns the status byte and clears it. A status bit that is set in the same cycle as that read is kept.
- R8: The irq output is high exactly when a status bit is set and its mask bit is clear. The mask bits are [2] message-end, [1] block-ready and [0] overflow, and a mask bit of 1 masks.
- R9: After reset the status byte and the count register read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Line byte valid |
| rx_data | input | 8 | Line byte |
| rx_eof | input | 1 | Marks the valid byte as the last byte of its frame |
| cfg_blk_sel | input | 2 | Block size select: 4 << value bytes |
| irq_mask | input | 3 | Interrupt masks {message-end, block-ready, overflow} |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 6 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the cycle of host_rd |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two pairs of actions can fall in the same cycle here. The first is a status read that clears the register on the edge where a newly released event sets its bit. The bench provokes this by issuing the status read directly after the release write, so the read meets the presenting edge. It then expects the read to return zero and the next read to return the message-end bit. The second is a line byte arriving against a full store: the bench overfills a 32-byte block and checks that the overflow bit is reported with block-ready, that the first 32 bytes are intact, and that the byte sent after the release is the next one delivered.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

  localparam int unsigned ADDR_STATUS = 32;
  localparam int unsigned ADDR_COUNT  = 33;
  localparam int unsigned ADDR_REL    = 34;
  localparam int unsigned WIN_SPAN    = 32;
  localparam logic [7:0]  REL_CMD     = 8'h80;

  localparam int unsigned BIT_ME  = 7;
  localparam int unsigned BIT_BR  = 6;
  localparam int unsigned BIT_OVF = 5;

  function automatic int unsigned blk_bytes(input logic [1:0] sel);
    return 32'd4 << sel;
  endfunction

  function automatic int unsigned last_piece(input int unsigned len,
                                             input int unsigned blk);
    int unsigned r;
    r = len % blk;
    return (r == 0) ? blk : r;
  endfunction

endpackage

// File: rtl/hrf_store.sv
module hrf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rel_en,
  input  logic [PW-1:0]     rel_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              accept,
  output logic              drop
);
  localparam int IW = PW - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, base;
  logic [PW-1:0] occ;
  logic          full;

  function automatic logic [PW-1:0] held(input logic [PW-1:0] w,
                                         input logic [PW-1:0] b);
    return w - b;
  endfunction

  assign occ     = held(wr_ptr, base);
  assign full    = (occ == PW'(DEPTH));
  assign accept  = wr_en && !full;
  assign drop    = wr_en && full;
  assign rd_data = mem[rd_ptr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr[IW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      base   <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + 1'b1;
      if (rel_en) begin
        base   <= base + rel_cnt;
        rd_ptr <= base + rel_cnt;
      end else if (rd_en) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));

  assert_drop_holds_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> $stable(wr_ptr));

endmodule

// File: rtl/hrf_evq.sv
module hrf_evq #(
  parameter int W     = 7,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int IW = PW - 1;

  logic [W-1:0]  ent [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full;

  assign empty = (wp == rp);
  assign full  = ((wp - rp) == PW'(DEPTH));
  assign head  = ent[rp[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push) ent[wp[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  assert_evq_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/hrf_host_regs.sv
module hrf_host_regs #(
  parameter int DATA_W = 8,
  parameter int CW     = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evq_empty,
  input  logic [CW:0]       evq_head,
  input  logic              ovf_evt,
  input  logic [DATA_W-1:0] fifo_byte,
  input  logic [2:0]        irq_mask,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              evq_pop,
  output logic              ev_fire,
  output logic              rel_en,
  output logic [CW-1:0]     rel_cnt,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  import hrf_pkg::*;

  logic              await_q;
  logic [CW-1:0]     cur_cnt_q;
  logic [CW-1:0]     bcnt_q;
  logic [DATA_W-1:0] isr_q, isr_nx;
  logic              win_hit, isr_rd, head_end;
  logic [CW-1:0]     head_cnt;
  logic [2:0]        pend;

  assign head_end = evq_head[CW];
  assign head_cnt = evq_head[CW-1:0];
  assign win_hit  = (host_addr < ADDR_W'(WIN_SPAN));
  assign fifo_rd  = host_rd && win_hit;
  assign isr_rd   = host_rd && (host_addr == ADDR_W'(ADDR_STATUS));
  assign rel_en   = host_wr && await_q &&
                    (host_addr == ADDR_W'(ADDR_REL)) &&
                    (host_wdata == DATA_W'(REL_CMD));
  assign ev_fire  = !await_q && !evq_empty;
  assign evq_pop  = ev_fire;
  assign rel_cnt  = cur_cnt_q;

  always_comb begin
    isr_nx = isr_rd ? '0 : isr_q;
    if (ev_fire &&  head_end) isr_nx[BIT_ME] = 1'b1;
    if (ev_fire && !head_end) isr_nx[BIT_BR] = 1'b1;
    if (ovf_evt)              isr_nx[BIT_OVF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      await_q   <= 1'b0;
      cur_cnt_q <= '0;
      bcnt_q    <= '0;
      isr_q     <= '0;
    end else begin
      isr_q <= isr_nx;
      if (ev_fire) begin
        await_q   <= 1'b1;
        cur_cnt_q <= head_cnt;
        if (head_end) bcnt_q <= head_cnt;
      end else if (rel_en) begin
        await_q <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (win_hit)                                     host_rdata = fifo_byte;
    else if (host_addr == ADDR_W'(ADDR_STATUS))      host_rdata = isr_q;
    else if (host_addr == ADDR_W'(ADDR_COUNT))       host_rdata = DATA_W'(bcnt_q);
  end

  assign pend = {isr_q[BIT_ME], isr_q[BIT_BR], isr_q[BIT_OVF]};
  assign irq  = |(pend & ~irq_mask);

  assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> !ev_fire);

  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fire |=> (isr_q[BIT_ME] || isr_q[BIT_BR]));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|pend));

endmodule

// File: rtl/hrf_rx_fifo_host.sv
module hrf_rx_fifo_host #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_eof,
  input  logic [1:0]        cfg_blk_sel,
  input  logic [2:0]        irq_mask,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq
);
  import hrf_pkg::*;

  localparam int CW = $clog2(DEPTH) + 1;

  logic              accept, drop;
  logic [CW-1:0]     part_q, part_nx, blk_sz;
  logic              push_en;
  logic [CW:0]       push_word, evq_head;
  logic              evq_empty, evq_pop, ev_fire;
  logic              rel_en, fifo_rd;
  logic [CW-1:0]     rel_cnt;
  logic [DATA_W-1:0] fifo_byte;

  assign blk_sz    = CW'(blk_bytes(cfg_blk_sel));
  assign part_nx   = part_q + 1'b1;
  assign push_en   = accept && (rx_eof || (part_nx >= blk_sz));
  assign push_word = {rx_eof, part_nx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       part_q <= '0;
    else if (push_en) part_q <= '0;
    else if (accept)  part_q <= part_nx;
  end

  hrf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rx_valid),
    .wr_data (rx_data),
    .rd_en   (fifo_rd),
    .rel_en  (rel_en),
    .rel_cnt (rel_cnt),
    .rd_data (fifo_byte),
    .accept  (accept),
    .drop    (drop)
  );

  hrf_evq #(.W(CW + 1), .DEPTH(DEPTH)) u_evq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_en),
    .push_data (push_word),
    .pop       (evq_pop),
    .head      (evq_head),
    .empty     (evq_empty)
  );

  hrf_host_regs #(.DATA_W(DATA_W), .CW(CW), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .evq_empty  (evq_empty),
    .evq_head   (evq_head),
    .ovf_evt    (drop),
    .fifo_byte  (fifo_byte),
    .irq_mask   (irq_mask),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .evq_pop    (evq_pop),
    .ev_fire    (ev_fire),
    .rel_en     (rel_en),
    .rel_cnt    (rel_cnt),
    .fifo_rd    (fifo_rd),
    .host_rdata (host_rdata),
    .irq        (irq)
  );

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && evq_head[CW]) |-> (evq_head[CW-1:0] != '0 &&
                                   evq_head[CW-1:0] <= blk_sz));

  assert_block_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !evq_head[CW]) |-> (evq_head[CW-1:0] == blk_sz));

endmodule

// File: tb/sim_hrf_rx_fifo_host.sv
module sim_hrf_rx_fifo_host;
  import hrf_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_eof = 1'b0;
  logic [1:0] cfg_blk_sel = '0;
  logic [2:0] irq_mask = '0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] fb [64];

  always #5 clk = ~clk;

  hrf_rx_fifo_host u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof(rx_eof), .cfg_blk_sel(cfg_blk_sel), .irq_mask(irq_mask),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic eof);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_eof = eof;
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic host_read(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic host_write(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int t = 0;
    while (!irq && t < 300) begin @(negedge clk); t++; end
    check(irq, tag, irq, 1);
  endtask

  task automatic send_frame(input int len, input logic last_eof);
    for (int i = 0; i < len; i++) send_byte(fb[i], last_eof && (i == len - 1));
  endtask

  // Expected events: full blocks, then a message end with the last piece.
  task automatic serve(input int b, input int len);
    logic [7:0] v;
    int nev = (len + b - 1) / b;
    for (int e = 0; e < nev; e++) begin
      int last = (e == nev - 1);
      int cnt = last ? int'(last_piece(len, b)) : b;
      wait_irq("R8 irq for event");
      host_read(6'h20, v);
      check(v == (last ? 8'h80 : 8'h40), last ? "R3 status me" : "R2 status br",
            v, last ? 8'h80 : 8'h40);
      if (last) begin
        host_read(6'h21, v);
        check(v == cnt, "R3 count", v, cnt);
      end
      for (int k = 0; k < cnt; k++) begin
        logic [5:0] a = 6'($urandom % 32);
        host_read(a, v);
        check(v == fb[e * b + k], "R1 window data", v, fb[e * b + k]);
      end
      host_write(6'h22, 8'h80);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    check(irq == 1'b0, "R9 irq low", irq, 0);
    host_read(6'h20, v); check(v == 8'h00, "R9 status zero", v, 0);
    host_read(6'h21, v); check(v == 8'h00, "R9 count zero", v, 0);

    // R3 boundary: frame of exactly one block gives only message end
    cfg_blk_sel = 2'd0;
    for (int i = 0; i < 4; i++) fb[i] = 8'(8'hA0 + i);
    send_frame(4, 1'b1);
    serve(4, 4);

    // R2 two blocks of 4, the second ending the frame
    for (int i = 0; i < 8; i++) fb[i] = 8'(8'h10 + i);
    send_frame(8, 1'b1);
    serve(4, 8);

    // R5 wrong release value ignored, R6 partial read then release
    for (int i = 0; i < 8; i++) fb[i] = 8'(8'h30 + i);
    send_frame(8, 1'b1);
    wait_irq("R8 irq br");
    host_read(6'h20, v); check(v == 8'h40, "R2 status br", v, 8'h40);
    host_read(6'h05, v); check(v == fb[0], "R1 first byte", v, fb[0]);
    host_read(6'h1F, v); check(v == fb[1], "R1 pointer advance", v, fb[1]);
    host_write(6'h22, 8'h81);
    repeat (4) @(negedge clk);
    check(irq == 1'b0, "R5 bad release irq", irq, 0);
    host_read(6'h20, v); check(v == 8'h00, "R5 bad release status", v, 0);
    host_write(6'h22, 8'h80);
    wait_irq("R8 irq me");
    host_read(6'h20, v); check(v == 8'h80, "R3 status me", v, 8'h80);
    host_read(6'h21, v); check(v == 8'd4, "R3 count four", v, 4);
    for (int k = 0; k < 4; k++) begin
      host_read(6'(k), v); check(v == fb[4 + k], "R6 pointer resync", v, fb[4 + k]);
    end
    host_write(6'h22, 8'h80);

    // R7 status read meets event set, R8 masking
    irq_mask = 3'b111;
    for (int i = 0; i < 8; i++) fb[i] = 8'(8'h50 + i);
    send_frame(8, 1'b1);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R8 masked irq", irq, 0);
    host_read(6'h20, v); check(v == 8'h40, "R2 status masked br", v, 8'h40);
    for (int k = 0; k < 4; k++) host_read(6'h00, v);
    host_write(6'h22, 8'h80);
    host_read(6'h20, v); check(v == 8'h00, "R7 read at set edge", v, 0);
    check(irq == 1'b0, "R8 me masked", irq, 0);
    @(negedge clk); irq_mask = 3'b011; #1;
    check(irq == 1'b1, "R8 me unmasked", irq, 1);
    host_read(6'h20, v); check(v == 8'h80, "R7 set kept", v, 8'h80);
    #1 check(irq == 1'b0, "R7 cleared irq", irq, 0);
    for (int k = 0; k < 4; k++) begin
      host_read(6'h10, v); check(v == fb[4 + k], "R1 data after mask", v, fb[4 + k]);
    end
    host_write(6'h22, 8'h80);
    irq_mask = 3'b000;

    // R4 overflow: 34 bytes against a 32-byte block
    cfg_blk_sel = 2'd3;
    for (int i = 0; i < 34; i++) fb[i] = 8'($urandom);
    send_frame(32, 1'b0);
    send_byte(8'hEE, 1'b0);
    send_byte(8'hEF, 1'b1);
    wait_irq("R8 irq overflow");
    host_read(6'h20, v); check(v == 8'h60, "R4 overflow with br", v, 8'h60);
    for (int k = 0; k < 32; k++) begin
      host_read(6'(k), v); check(v == fb[k], "R4 stored bytes intact", v, fb[k]);
    end
    host_write(6'h22, 8'h80);
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R4 dropped eof no event", irq, 0);
    send_byte(8'h5A, 1'b1);
    wait_irq("R8 irq after overflow");
    host_read(6'h20, v); check(v == 8'h80, "R4 status after drop", v, 8'h80);
    host_read(6'h21, v); check(v == 8'd1, "R3 count one", v, 1);
    host_read(6'h07, v); check(v == 8'h5A, "R6 next byte after release", v, 8'h5A);
    host_write(6'h22, 8'h80);

    // Random frames over all block sizes
    for (int n = 0; n < 40; n++) begin
      int sel = int'($urandom % 4);
      int len = 1 + int'($urandom % 32);
      cfg_blk_sel = 2'(sel);
      for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
      send_frame(len, 1'b1);
      serve(int'(blk_bytes(2'(sel))), len);
    end

    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R5 idle at end", irq, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule